// File: doc/BRIEF.md
# Three-Operand Register Soft Processor Core

This block is a small load/store processor for soft-logic targets. It has a 24-bit data path, 24-bit instructions and word addressing. Its 64 general registers sit in an asynchronous-read, synchronous-write array. A single synchronous-read memory holds both the program and the data. Each instruction word begins with a 6-bit operation code. The remaining 18 bits carry either three 6-bit register fields or an immediate of 6, 12 or 18 bits, and each immediate takes the place of one, two or three register fields.

Every instruction except a load finishes in one clock. The word fetched on the previous edge is decoded, its operands are read from the register array, the result is formed, and on the next edge the result is written back while the following word is fetched. A load takes one extra clock, because the single read port of the memory is needed to fetch the data word.

The only way out of the core is an output port driven by an output instruction. The program is placed in memory through a preload write port while the core is held in reset.

Top module: `tri_reg_cpu`

## Requirements
- R1: While rst_n is low, out_strobe and out_data are 0, and the carry, zero and negative flags are cleared. After rst_n rises, the core spends two clock edges releasing its internal reset and one edge fetching address 0. The word at address 0 executes on the fourth rising edge after the release.
- R2: Register format: opcode in bits [23:18], destination rd in [17:12], source ra in [11:6] and source rb in [5:0]. Opcode 1 writes ra+rb to rd, 2 writes ra-rb, 3 writes ra AND rb, 4 writes ra OR rb, and 5 writes ra XOR rb.
- R3: Opcode 6 writes ra plus the 6-bit immediate in bits [5:0], zero-extended, to rd. Opcode 7 writes ra plus that immediate plus the carry flag to rd. This lets two registers form a 48-bit counter.
- R4: Opcode 8 writes the 12-bit immediate in bits [11:0], zero-extended, to rd and leaves the flags unchanged.
- R5: Opcodes 1, 6 and 7 set the carry flag to the carry out of bit 23. Opcode 2 sets carry when ra is below rb as an unsigned number. All four set the zero flag when the result is 0 and the negative flag to result bit 23. Opcodes 3 to 5 update only the zero and negative flags. No other opcode changes any flag.
- R6: Opcode 12 always jumps, and opcodes 13, 14 and 15 jump when the carry, zero or negative flag is set. The target is the absolute 18-bit field [17:0], of which the low memory-address bits are used. A branch that is not taken goes on to the next word.
- R7: Opcode 9 loads mem[ra + imm6] into rd and takes two clocks. Opcode 10 stores register rd into mem[ra + imm6] in one clock. The imm6 field is bits [5:0], zero-extended, and the address wraps to the memory size.
- R8: Opcode 11 places register ra on out_data from the edge that completes it, and raises out_strobe for exactly that one cycle. out_data holds its value until the next output instruction.
- R9: Opcode 0 and opcodes 16 to 63 leave the registers, flags, memory and output port unchanged and advance to the next word.
- R10: Every instruction other than a load retires in one clock, and the following instruction executes on the next edge.
- R11: A rising edge with pl_we high writes pl_data into memory at pl_addr. This port is used while the core is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| pl_we | input | 1 | Preload write enable for program/data memory |
| pl_addr | input | MEM_AW (10) | Preload word address |
| pl_data | input | DATA_W (24) | Preload word |
| out_data | output | DATA_W (24) | Value of the last output instruction |
| out_strobe | output | 1 | One-cycle pulse per executed output instruction |

## Verification
Any wrong internal state reaches the ports only through the output instruction, so each test program routes its results, flag decisions and loaded words through out_data. A bad register write, a wrong flag or a mistaken branch changes either the value on the next output or whether a skipped output appears. The bench compares out_strobe and out_data against a behavioural model on every clock, which also catches timing faults. A load that takes the wrong number of cycles, or a stalled or skipped fetch, moves the next strobe off its expected edge within a few clocks.

// File: rtl/tri_cpu_pkg.sv
package tri_cpu_pkg;

  // Width of one instruction field; opcode and each operand field share it.
  localparam int FW = 6;
  localparam int IW = 4 * FW;

  localparam logic [FW-1:0] OP_NOP  = 6'd0;
  localparam logic [FW-1:0] OP_ADD  = 6'd1;
  localparam logic [FW-1:0] OP_SUB  = 6'd2;
  localparam logic [FW-1:0] OP_AND  = 6'd3;
  localparam logic [FW-1:0] OP_OR   = 6'd4;
  localparam logic [FW-1:0] OP_XOR  = 6'd5;
  localparam logic [FW-1:0] OP_ADDI = 6'd6;
  localparam logic [FW-1:0] OP_ADCI = 6'd7;
  localparam logic [FW-1:0] OP_LDI  = 6'd8;
  localparam logic [FW-1:0] OP_LD   = 6'd9;
  localparam logic [FW-1:0] OP_ST   = 6'd10;
  localparam logic [FW-1:0] OP_OUT  = 6'd11;
  localparam logic [FW-1:0] OP_JMP  = 6'd12;
  localparam logic [FW-1:0] OP_BRC  = 6'd13;
  localparam logic [FW-1:0] OP_BRZ  = 6'd14;
  localparam logic [FW-1:0] OP_BRN  = 6'd15;

  typedef enum logic [1:0] {
    CS_BOOT = 2'd0,
    CS_EXEC = 2'd1,
    CS_LOAD = 2'd2
  } core_state_t;

  typedef enum logic [2:0] {
    AF_ADD = 3'd0,
    AF_ADC = 3'd1,
    AF_SUB = 3'd2,
    AF_AND = 3'd3,
    AF_OR  = 3'd4,
    AF_XOR = 3'd5
  } alu_fn_t;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
  } cpu_flags_t;

endpackage

// File: rtl/tri_cpu_regfile.sv
module tri_cpu_regfile #(
  parameter int DW  = 24,
  parameter int AW  = 6,
  parameter int NRD = 3
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    assign rdata[p] = cells[raddr[p]];
  end

endmodule

// File: rtl/tri_cpu_mem.sv
module tri_cpu_mem #(
  parameter int DW = 24,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      words[waddr] <= wdata;
    end
  end

  // Read returns the contents before a same-edge write.
  always_ff @(posedge clk) begin
    rdata_q <= words[raddr];
  end

endmodule

// File: rtl/tri_cpu_alu.sv
module tri_cpu_alu
  import tri_cpu_pkg::*;
#(
  parameter int DW = 24
) (
  input  alu_fn_t       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);

  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    unique case (fn)
      AF_ADD:  wide = {1'b0, a} + {1'b0, b};
      AF_ADC:  wide = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);
      AF_SUB:  wide = {(a < b), a - b};
      AF_AND:  wide = {1'b0, a & b};
      AF_OR:   wide = {1'b0, a | b};
      AF_XOR:  wide = {1'b0, a ^ b};
      default: wide = '0;
    endcase
    res  = wide[DW-1:0];
    cout = wide[DW];
  end

endmodule

// File: rtl/tri_reg_cpu.sv
module tri_reg_cpu
  import tri_cpu_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_strobe
);

  localparam int NRD = 3;
  localparam int RP_A = 0;
  localparam int RP_B = 1;
  localparam int RP_D = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      core_rst_n <= rst_meta_q;
    end
  end

  core_state_t       state_q, state_d;
  logic [MEM_AW-1:0] pc_q, pc_d;
  cpu_flags_t        flg_q, flg_d;
  logic [DATA_W-1:0] outd_q, outd_d;
  logic              outs_q, outs_d;
  logic [FW-1:0]     ldrd_q, ldrd_d;

  logic [DATA_W-1:0] mem_q;
  logic [MEM_AW-1:0] mem_raddr;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              st_we;

  logic                      rf_we;
  logic [FW-1:0]             rf_waddr;
  logic [DATA_W-1:0]         rf_wdata;
  logic [NRD-1:0][FW-1:0]    rf_raddr;
  logic [NRD-1:0][DATA_W-1:0] rf_rdata;

  // Instruction fields
  logic [IW-1:0]     ir;
  logic [FW-1:0]     op, f_rd, f_ra, f_rb;
  logic [2*FW-1:0]   imm12;
  logic [3*FW-1:0]   imm18;
  logic [DATA_W-1:0] ra_val, rb_val, rd_val, imm6_x, imm12_x;
  logic [MEM_AW-1:0] eff_addr, pc_inc, br_tgt;
  logic              is_exec, undef_op, br_take;

  assign ir      = mem_q[IW-1:0];
  assign op      = ir[4*FW-1:3*FW];
  assign f_rd    = ir[3*FW-1:2*FW];
  assign f_ra    = ir[2*FW-1:FW];
  assign f_rb    = ir[FW-1:0];
  assign imm12   = ir[2*FW-1:0];
  assign imm18   = ir[3*FW-1:0];
  assign imm6_x  = DATA_W'(f_rb);
  assign imm12_x = DATA_W'(imm12);
  assign is_exec = (state_q == CS_EXEC);
  assign undef_op = (op == OP_NOP) || (op > OP_BRN);

  assign rf_raddr[RP_A] = f_ra;
  assign rf_raddr[RP_B] = f_rb;
  assign rf_raddr[RP_D] = f_rd;
  assign ra_val = rf_rdata[RP_A];
  assign rb_val = rf_rdata[RP_B];
  assign rd_val = rf_rdata[RP_D];

  assign eff_addr = MEM_AW'(ra_val + imm6_x);
  assign pc_inc   = pc_q + MEM_AW'(1);
  assign br_tgt   = MEM_AW'(imm18);

  // ALU operand and function selection
  alu_fn_t           alu_fn;
  logic [DATA_W-1:0] alu_b, alu_res;
  logic              alu_cout;

  always_comb begin
    alu_fn = AF_ADD;
    alu_b  = rb_val;
    unique case (op)
      OP_SUB:  alu_fn = AF_SUB;
      OP_AND:  alu_fn = AF_AND;
      OP_OR:   alu_fn = AF_OR;
      OP_XOR:  alu_fn = AF_XOR;
      OP_ADDI: alu_b  = imm6_x;
      OP_ADCI: begin
        alu_fn = AF_ADC;
        alu_b  = imm6_x;
      end
      default: alu_fn = AF_ADD;
    endcase
  end

  tri_cpu_alu #(.DW(DATA_W)) u_alu (
    .fn   (alu_fn),
    .a    (ra_val),
    .b    (alu_b),
    .cin  (flg_q.c),
    .res  (alu_res),
    .cout (alu_cout)
  );

  always_comb begin
    unique case (op)
      OP_JMP:  br_take = 1'b1;
      OP_BRC:  br_take = flg_q.c;
      OP_BRZ:  br_take = flg_q.z;
      OP_BRN:  br_take = flg_q.n;
      default: br_take = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    flg_d     = flg_q;
    outd_d    = outd_q;
    outs_d    = 1'b0;
    ldrd_d    = ldrd_q;
    rf_we     = 1'b0;
    rf_waddr  = f_rd;
    rf_wdata  = alu_res;
    st_we     = 1'b0;
    mem_raddr = pc_q;
    unique case (state_q)
      CS_BOOT: begin
        state_d = CS_EXEC;
      end
      CS_EXEC: begin
        pc_d = br_take ? br_tgt : pc_inc;
        unique case (op)
          OP_ADD, OP_SUB, OP_ADDI, OP_ADCI: begin
            rf_we   = 1'b1;
            flg_d.c = alu_cout;
            flg_d.z = (alu_res == '0);
            flg_d.n = alu_res[DATA_W-1];
          end
          OP_AND, OP_OR, OP_XOR: begin
            rf_we   = 1'b1;
            flg_d.z = (alu_res == '0);
            flg_d.n = alu_res[DATA_W-1];
          end
          OP_LDI: begin
            rf_we    = 1'b1;
            rf_wdata = imm12_x;
          end
          OP_LD: begin
            ldrd_d  = f_rd;
            state_d = CS_LOAD;
          end
          OP_ST: st_we = 1'b1;
          OP_OUT: begin
            outd_d = ra_val;
            outs_d = 1'b1;
          end
          default: rf_we = 1'b0;
        endcase
        mem_raddr = (op == OP_LD) ? eff_addr : pc_d;
      end
      CS_LOAD: begin
        rf_we    = 1'b1;
        rf_waddr = ldrd_q;
        rf_wdata = mem_q;
        state_d  = CS_EXEC;
      end
      default: state_d = CS_BOOT;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= CS_BOOT;
      pc_q    <= '0;
      flg_q   <= '0;
      outd_q  <= '0;
      outs_q  <= 1'b0;
      ldrd_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      flg_q   <= flg_d;
      outd_q  <= outd_d;
      outs_q  <= outs_d;
      ldrd_q  <= ldrd_d;
    end
  end

  // Memory write port: preload has priority over stores.
  assign mem_we    = pl_we | st_we;
  assign mem_waddr = pl_we ? pl_addr : eff_addr;
  assign mem_wdata = pl_we ? pl_data : rd_val;

  tri_cpu_mem #(.DW(DATA_W), .AW(MEM_AW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (mem_raddr),
    .rdata_q (mem_q)
  );

  tri_cpu_regfile #(.DW(DATA_W), .AW(FW), .NRD(NRD)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign out_data   = outd_q;
  assign out_strobe = outs_q;

  // Checks
  assert_boot_at_zero_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == CS_BOOT) |-> (pc_q == '0));

  assert_load_enters_wait_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_exec && op == OP_LD) |=> (state_q == CS_LOAD));

  assert_load_wait_one_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == CS_LOAD) |=> (state_q == CS_EXEC));

  assert_strobe_from_exec_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_strobe |-> ($past(state_q) == CS_EXEC));

  assert_undef_keeps_flags_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_exec && undef_op) |=> ($stable(flg_q) && !out_strobe));

  assert_seq_pc_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_exec && !br_take) |=> (pc_q == MEM_AW'($past(pc_q) + 1'b1)));

endmodule

// File: tb/tri_reg_cpu_bench.sv
module tri_reg_cpu_bench;

  localparam int DW = 24;
  localparam int AW = 10;
  localparam int MDEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [DW-1:0] pl_data = '0;
  logic [DW-1:0] out_data;
  logic          out_strobe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tri_reg_cpu #(.DATA_W(DW), .MEM_AW(AW)) u_tri_reg_cpu (
    .clk        (clk),
    .rst_n      (rst_n),
    .pl_we      (pl_we),
    .pl_addr    (pl_addr),
    .pl_data    (pl_data),
    .out_data   (out_data),
    .out_strobe (out_strobe)
  );

  // Behavioural reference model
  logic [DW-1:0] m_mem [MDEPTH];
  logic [DW-1:0] m_rf [64];
  bit            m_on = 1'b0;
  int            m_phase;
  int            m_pc;
  bit            mc, mz, mn;
  logic [DW-1:0] m_out;
  bit            m_stb;
  int            m_ldrd;
  logic [DW-1:0] m_lddata;
  string         cur_tag;

  task automatic model_exec();
    logic [DW-1:0] w, a, r;
    logic [DW:0]   s;
    int op, rd, ra, rb, npc;
    w  = m_mem[m_pc];
    op = int'(w[23:18]); rd = int'(w[17:12]); ra = int'(w[11:6]); rb = int'(w[5:0]);
    a  = m_rf[ra];
    npc = (m_pc + 1) % MDEPTH;
    m_stb = 1'b0;
    case (op)
      1, 6, 7: begin
        if (op == 1) s = {1'b0, a} + {1'b0, m_rf[rb]};
        else s = {1'b0, a} + 25'(rb) + ((op == 7 && mc) ? 25'd1 : 25'd0);
        r = s[23:0]; mc = s[24];
        mz = (r == 0); mn = r[23]; m_rf[rd] = r;
      end
      2: begin
        r = a - m_rf[rb]; mc = (a < m_rf[rb]);
        mz = (r == 0); mn = r[23]; m_rf[rd] = r;
      end
      3, 4, 5: begin
        if (op == 3) r = a & m_rf[rb];
        else if (op == 4) r = a | m_rf[rb];
        else r = a ^ m_rf[rb];
        mz = (r == 0); mn = r[23]; m_rf[rd] = r;
      end
      8: m_rf[rd] = 24'(w[11:0]);
      9: begin
        m_ldrd = rd;
        m_lddata = m_mem[(int'(a) + rb) % MDEPTH];
        m_phase = 2;
      end
      10: m_mem[(int'(a) + rb) % MDEPTH] = m_rf[rd];
      11: begin m_out = a; m_stb = 1'b1; end
      12: npc = int'(w[17:0]) % MDEPTH;
      13: if (mc) npc = int'(w[17:0]) % MDEPTH;
      14: if (mz) npc = int'(w[17:0]) % MDEPTH;
      15: if (mn) npc = int'(w[17:0]) % MDEPTH;
      default: ;
    endcase
    m_pc = npc;
  endtask

  always @(posedge clk) begin
    if (m_on) begin
      case (m_phase)
        -2: m_phase = -1;
        -1: m_phase = 0;
        0:  m_phase = 1;
        1:  model_exec();
        default: begin
          m_rf[m_ldrd] = m_lddata;
          m_stb = 1'b0;
          m_phase = 1;
        end
      endcase
    end
  end

  // Encoders
  function automatic logic [DW-1:0] enc_r(int op, int rd, int ra, int rb);
    return {op[5:0], rd[5:0], ra[5:0], rb[5:0]};
  endfunction
  function automatic logic [DW-1:0] enc_i(int op, int rd, int imm);
    return {op[5:0], rd[5:0], imm[11:0]};
  endfunction
  function automatic logic [DW-1:0] enc_j(int op, int tgt);
    return {op[5:0], tgt[17:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [DW:0] act, logic [DW:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_on  = 1'b0;
    @(negedge clk);
    chk(out_strobe === 1'b0 && out_data === '0, "R1 reset outputs",
        {out_strobe, out_data}, '0);
  endtask

  task automatic put(int a, logic [DW-1:0] w);
    pl_we   = 1'b1;
    pl_addr = a[AW-1:0];
    pl_data = w;
    m_mem[a] = w;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic run(string tag, int cycles);
    m_phase = -2; m_pc = 0; mc = 0; mz = 0; mn = 0;
    m_out = '0; m_stb = 1'b0; m_ldrd = 0; m_lddata = '0;
    cur_tag = tag;
    rst_n = 1'b1;
    m_on  = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(out_strobe === m_stb && out_data === m_out, cur_tag,
          {out_strobe, out_data}, {m_stb, m_out});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Program 1: register ALU ops, flags, branches, output (R1 R2 R4 R5 R6 R8 R10)
    hold_reset();
    put(0,  enc_i(8, 1, 'h123));
    put(1,  enc_i(8, 2, 'hFFF));
    put(2,  enc_r(1, 3, 1, 2));
    put(3,  enc_r(11, 0, 3, 0));
    put(4,  enc_r(2, 4, 1, 2));
    put(5,  enc_r(11, 0, 4, 0));
    put(6,  enc_j(15, 8));
    put(7,  enc_r(11, 0, 1, 0));
    put(8,  enc_j(13, 10));
    put(9,  enc_r(11, 0, 2, 0));
    put(10, enc_r(3, 5, 1, 2));
    put(11, enc_r(11, 0, 5, 0));
    put(12, enc_r(4, 6, 4, 1));
    put(13, enc_r(11, 0, 6, 0));
    put(14, enc_r(5, 7, 1, 1));
    put(15, enc_j(14, 17));
    put(16, enc_r(11, 0, 2, 0));
    put(17, enc_r(11, 0, 7, 0));
    put(18, enc_r(1, 8, 4, 4));
    put(19, enc_j(13, 21));
    put(20, enc_r(11, 0, 1, 0));
    put(21, enc_r(11, 0, 8, 0));
    put(22, enc_r(2, 9, 2, 1));
    put(23, enc_j(13, 25));
    put(24, enc_r(11, 0, 9, 0));
    put(25, enc_j(14, 27));
    put(26, enc_r(11, 0, 2, 0));
    put(27, enc_j(12, 27));
    run("R1 R2 R4 R5 R6 R8 R10", 50);

    // Program 2: 48-bit counter through carry chain (R3 R5)
    hold_reset();
    put(0,  enc_i(8, 1, 0));
    put(1,  enc_i(8, 2, 1));
    put(2,  enc_r(2, 10, 1, 2));
    put(3,  enc_i(8, 11, 5));
    put(4,  enc_r(6, 10, 10, 1));
    put(5,  enc_r(7, 11, 11, 0));
    put(6,  enc_r(11, 0, 10, 0));
    put(7,  enc_r(11, 0, 11, 0));
    put(8,  enc_r(6, 12, 11, 63));
    put(9,  enc_r(11, 0, 12, 0));
    put(10, enc_j(12, 4));
    run("R3 R5 R8", 60);

    // Program 3: loads, stores, preloaded data (R7 R11)
    hold_reset();
    put('h300, 24'h5A5A5A);
    put('h301, 24'h000777);
    put(0,  enc_i(8, 1, 'h300));
    put(1,  enc_r(9, 2, 1, 0));
    put(2,  enc_r(11, 0, 2, 0));
    put(3,  enc_r(9, 3, 1, 1));
    put(4,  enc_r(1, 5, 2, 3));
    put(5,  enc_r(11, 0, 5, 0));
    put(6,  enc_r(10, 5, 1, 5));
    put(7,  enc_r(9, 6, 1, 5));
    put(8,  enc_r(11, 0, 6, 0));
    put(9,  enc_r(10, 2, 1, 63));
    put(10, enc_r(9, 8, 1, 63));
    put(11, enc_r(11, 0, 8, 0));
    put(12, enc_r(9, 9, 1, 1));
    put(13, enc_r(9, 10, 1, 0));
    put(14, enc_r(1, 11, 9, 10));
    put(15, enc_r(11, 0, 11, 0));
    put(16, enc_j(12, 16));
    run("R7 R11 R10", 50);

    // Program 4: undefined opcodes have no effect, branch conditions (R9 R6)
    hold_reset();
    put(0,  enc_i(8, 1, 0));
    put(1,  enc_i(8, 2, 1));
    put(2,  enc_r(2, 3, 1, 2));
    put(3,  enc_r(63, 3, 1, 2));
    put(4,  enc_r(11, 0, 3, 0));
    put(5,  enc_r(32, 3, 2, 2));
    put(6,  enc_j(13, 8));
    put(7,  enc_r(11, 0, 1, 0));
    put(8,  enc_j(15, 10));
    put(9,  enc_r(11, 0, 1, 0));
    put(10, enc_r(0, 2, 3, 3));
    put(11, enc_r(11, 0, 2, 0));
    put(12, enc_r(16, 2, 1, 1));
    put(13, enc_j(14, 15));
    put(14, enc_r(11, 0, 2, 0));
    put(15, enc_j(12, 17));
    put(16, enc_r(11, 0, 3, 0));
    put(17, enc_j(12, 17));
    run("R9 R6", 40);

    hold_reset();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule